// File: doc/BRIEF.md
# Programmable Almost-Empty Flag Generator

This block sits in the read-clock domain of a dual-clock FIFO. It works out how many words the FIFO memory holds and drives a status flag that is low while that count is at or below a programmable threshold X, and high once the count exceeds X. The write pointer arrives from the write domain as a Gray-coded value. The block passes it through a short synchronizer and then converts it to binary. The read side supplies its own binary read pointer and a bit that shows whether the output register currently holds a word.

A word sitting in the output register has already left the memory, so it is subtracted from the count. Pointers carry one bit more than the address, which keeps a completely full memory apart from an empty one. The threshold register takes a preset value during reset and can be rewritten from a parallel port on any read-clock edge where the load enable is high. A new write reaches the flag only after two read-clock edges. A read, a change in output-register occupancy or a threshold load acts on the flag as soon as the new value is present.

Top module: `aef_almost_empty_gen`

## Requirements
- R1: While `rst_rd_n` is low on a rising edge of `clk_rd`, the synchronizer stages clear to zero and the threshold register takes `OFFSET_PRESET` (default 8). After reset, with no writes, `above_x` is 0.
- R2: `above_x` is 1 when the memory fill level is greater than X, and 0 when the level is X or less.
- R3: On a rising edge where `cfg_load_en` is 1, X takes `cfg_offset`, and the compare uses the new value from then on. On an edge where `cfg_load_en` is 0, X keeps its value whatever `cfg_offset` carries.
- R4: The fill level is the synchronized write pointer minus `rd_ptr`, minus 1 when `out_occ` is 1. A word held in the output register is not counted.
- R5: A change of `wr_ptr_gray` reaches `above_x` on the second rising edge of `clk_rd` after it. A write that raises the level to X+1 sets the flag on that edge and not before.
- R6: A change of `rd_ptr` or `out_occ` that lowers the level to X clears `above_x` in the same cycle, with no synchronization delay.
- R7: Pointers are modulo 2^(ADDR_W+1). `wr_ptr_gray` is the reflected binary Gray code of the write count (g = b XOR (b>>1)). The level stays correct across pointer wrap-around.
- R8: A full memory, with a level of 2^ADDR_W, counts as full and not as empty. With X = 2^ADDR_W - 1 and a full memory, the flag is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_rd | input | 1 | Read-domain clock |
| rst_rd_n | input | 1 | Synchronous active-low reset |
| wr_ptr_gray | input | ADDR_W+1 | Gray-coded write pointer from the write domain |
| rd_ptr | input | ADDR_W+1 | Binary read pointer of the word the reader consumes next |
| out_occ | input | 1 | Output register holds a word already fetched from memory |
| cfg_load_en | input | 1 | Load enable for the threshold register |
| cfg_offset | input | ADDR_W | New threshold value X |
| above_x | output | 1 | High when the memory holds more than X words |

## Verification
Each result has its own due cycle. A write-pointer change shows at the output only from the second read-clock edge after it. A threshold load acts from the first edge on which the enable is sampled. Read pointer and occupancy changes act in the same cycle. The bench drives every input just after a falling edge and compares the flag at the next falling edge against a model. That model pushes the write count through two per-edge delay slots and applies the read-side values with no delay. Directed checks sample the flag once after the first edge and once after the second, so a flag that is one edge early or one edge late is caught.

// File: rtl/aef_pkg.sv
// Shared helpers for the almost-empty flag generator.
// Assumes pointer widths of at most 32 bits.
package aef_pkg;

    // Convert a reflected-binary Gray value to plain binary.
    function automatic logic [31:0] gray_to_bin(input logic [31:0] g);
        logic [31:0] b;
        b[31] = g[31];
        for (int i = 30; i >= 0; i--) begin
            b[i] = b[i+1] ^ g[i];
        end
        return b;
    endfunction

endpackage

// File: rtl/aef_gray_sync.sv
// Multi-stage synchronizer for a Gray-coded pointer entering the read domain.
// Assumes the source changes by at most one bit between samples (Gray code),
// so any captured value is either the old or the new pointer.
module aef_gray_sync #(
    parameter int W      = 7,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_async,
    output logic [W-1:0] q_sync
);

    logic [W-1:0] stg [STAGES];

    for (genvar i = 0; i < STAGES; i++) begin : g_stage
        if (i == 0) begin : g_first
            // Capture the asynchronous pointer into the first flop.
            always_ff @(posedge clk) begin
                if (!rst_n) stg[0] <= '0;
                else        stg[0] <= d_async;
            end
        end else begin : g_next
            // Pass the pointer one stage further down the chain.
            always_ff @(posedge clk) begin
                if (!rst_n) stg[i] <= '0;
                else        stg[i] <= stg[i-1];
            end
        end
    end

    assign q_sync = stg[STAGES-1];

endmodule

// File: rtl/aef_offset_reg.sv
// Threshold register X. Takes PRESET during reset and loads a new value
// only on edges where load_en is high.
module aef_offset_reg #(
    parameter int W      = 6,
    parameter int PRESET = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load_en,
    input  logic [W-1:0] load_val,
    output logic [W-1:0] offset_q
);

    // Hold, preset or load the threshold.
    always_ff @(posedge clk) begin
        if (!rst_n)       offset_q <= W'(PRESET);
        else if (load_en) offset_q <= load_val;
    end

endmodule

// File: rtl/aef_level_cmp.sv
// Fill-level arithmetic and threshold compare.
// Assumes wr_gray is already synchronized and rd_ptr/out_occ are registered
// read-domain values; the result is pure combinational logic on them.
module aef_level_cmp #(
    parameter int ADDR_W = 6
) (
    input  logic [ADDR_W:0]   wr_gray,
    input  logic [ADDR_W:0]   rd_ptr,
    input  logic              out_occ,
    input  logic [ADDR_W-1:0] offset,
    output logic              above
);

    localparam int PW = ADDR_W + 1;

    logic [PW-1:0] wr_bin;
    logic [PW-1:0] level;

    // Decode the pointer, subtract consumed and prefetched words, compare.
    always_comb begin
        wr_bin = PW'(aef_pkg::gray_to_bin(32'(wr_gray)));
        level  = wr_bin - rd_ptr - PW'(out_occ);
        above  = level > {1'b0, offset};
    end

endmodule

// File: rtl/aef_almost_empty_gen.sv
// Almost-empty flag generator for the read side of a dual-clock FIFO.
// above_x is high when the memory holds more than X words. Writes reach the
// flag after SYNC_STAGES read edges; read-side changes act at once.
// Assumes rd_ptr and out_occ come straight from read-domain registers.
module aef_almost_empty_gen #(
    parameter int ADDR_W        = 6,
    parameter int SYNC_STAGES   = 2,
    parameter int OFFSET_PRESET = 8
) (
    input  logic              clk_rd,
    input  logic              rst_rd_n,
    input  logic [ADDR_W:0]   wr_ptr_gray,
    input  logic [ADDR_W:0]   rd_ptr,
    input  logic              out_occ,
    input  logic              cfg_load_en,
    input  logic [ADDR_W-1:0] cfg_offset,
    output logic              above_x
);

    localparam int PW = ADDR_W + 1;

    logic [PW-1:0]     wr_gray_sync;
    logic [ADDR_W-1:0] offset_q;

    aef_gray_sync #(.W(PW), .STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk_rd),
        .rst_n   (rst_rd_n),
        .d_async (wr_ptr_gray),
        .q_sync  (wr_gray_sync)
    );

    aef_offset_reg #(.W(ADDR_W), .PRESET(OFFSET_PRESET)) u_off (
        .clk      (clk_rd),
        .rst_n    (rst_rd_n),
        .load_en  (cfg_load_en),
        .load_val (cfg_offset),
        .offset_q (offset_q)
    );

    aef_level_cmp #(.ADDR_W(ADDR_W)) u_cmp (
        .wr_gray (wr_gray_sync),
        .rd_ptr  (rd_ptr),
        .out_occ (out_occ),
        .offset  (offset_q),
        .above   (above_x)
    );

endmodule

// File: rtl/aef_checker.sv
// Temporal properties for the almost-empty flag generator, bound to the top.
// The lag property assumes the default two synchronizer stages.
module aef_checker #(
    parameter int ADDR_W        = 6,
    parameter int SYNC_STAGES   = 2,
    parameter int OFFSET_PRESET = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W:0]   wr_ptr_gray,
    input logic [ADDR_W:0]   rd_ptr,
    input logic              out_occ,
    input logic              cfg_load_en,
    input logic [ADDR_W-1:0] cfg_offset,
    input logic [ADDR_W-1:0] offset_q,
    input logic              above_x
);

    localparam int PW = ADDR_W + 1;

    logic [1:0] cyc;

    // Count edges since reset release, saturating at 3.
    always_ff @(posedge clk) begin
        if (!rst_n)         cyc <= 2'd0;
        else if (cyc != 2'd3) cyc <= cyc + 2'd1;
    end

    function automatic logic [PW-1:0] lvl(input logic [PW-1:0] g,
                                          input logic [PW-1:0] r,
                                          input logic o);
        return PW'(aef_pkg::gray_to_bin(32'(g))) - r - PW'(o);
    endfunction

    p_preset_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> offset_q == ADDR_W'(OFFSET_PRESET));

    p_load_r3: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_load_en |=> offset_q == $past(cfg_offset));

    p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_load_en |=> $stable(offset_q));

    if (SYNC_STAGES == 2) begin : g_lag
        // R2, R4 and R5: flag equals the compare on the two-edge-old pointer.
        p_lag_r5: assert property (@(posedge clk) disable iff (!rst_n)
            (cyc >= 2'd2) |->
            above_x == (lvl($past(wr_ptr_gray, 2), rd_ptr, out_occ) > {1'b0, offset_q}));
    end

endmodule

bind aef_almost_empty_gen aef_checker #(
    .ADDR_W(ADDR_W), .SYNC_STAGES(SYNC_STAGES), .OFFSET_PRESET(OFFSET_PRESET)
) u_chk (
    .clk         (clk_rd),
    .rst_n       (rst_rd_n),
    .wr_ptr_gray (wr_ptr_gray),
    .rd_ptr      (rd_ptr),
    .out_occ     (out_occ),
    .cfg_load_en (cfg_load_en),
    .cfg_offset  (cfg_offset),
    .offset_q    (offset_q),
    .above_x     (above_x)
);

// File: tb/sim_aef_almost_empty_gen.sv
// Bench for the almost-empty flag generator: a behavioural model with a
// two-slot write-count delay line, compared on every falling edge.
module sim_aef_almost_empty_gen;

    localparam int ADDR_W = 6;
    localparam int DEPTH  = 1 << ADDR_W;
    localparam int MOD    = DEPTH * 2;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [ADDR_W:0]   wr_ptr_gray = '0;
    logic [ADDR_W:0]   rd_ptr = '0;
    logic              out_occ = 1'b0;
    logic              cfg_load_en = 1'b0;
    logic [ADDR_W-1:0] cfg_offset = '0;
    logic              above_x;

    int    vectors = 0;
    int    miscompares = 0;
    int    wr_cnt = 0, rd_cnt = 0, occ_i = 0;
    int    s_dly[$];
    int    xm = 8;
    bit    done = 0;
    string cur_req = "R1";

    always #10 clk = ~clk;

    aef_almost_empty_gen u0 (
        .clk_rd (clk), .rst_rd_n (rst_n), .wr_ptr_gray (wr_ptr_gray),
        .rd_ptr (rd_ptr), .out_occ (out_occ), .cfg_load_en (cfg_load_en),
        .cfg_offset (cfg_offset), .above_x (above_x)
    );

    // Model: write count seen after two edges, threshold loaded at the edge.
    always @(posedge clk) begin
        if (!rst_n) begin
            s_dly = '{0, 0};
            xm = 8;
        end else begin
            void'(s_dly.pop_front());
            s_dly.push_back(wr_cnt);
            if (cfg_load_en) xm = int'(cfg_offset);
        end
    end

    function automatic int vis_level();
        return ((s_dly[0] - rd_cnt - occ_i) % MOD + MOD) % MOD;
    endfunction

    function automatic bit model_flag();
        return vis_level() > xm;
    endfunction

    task automatic chk(input bit got, input bit exp, input string req);
        vectors++;
        if (got !== exp) begin
            miscompares++;
            $display("FAIL %s t=%0t above_x actual=%0b expected=%0b", req, $time, got, exp);
        end
    endtask

    // Compare every cycle, just before inputs are driven.
    always @(negedge clk) if (s_dly.size() == 2 && !done) chk(above_x, model_flag(), cur_req);

    task automatic drive();
        int b;
        b = wr_cnt % MOD;
        wr_ptr_gray = (ADDR_W+1)'(b ^ (b >> 1));
        rd_ptr      = (ADDR_W+1)'(rd_cnt % MOD);
        out_occ     = occ_i[0];
    endtask

    // Wait for the next compare point, then allow new inputs.
    task automatic tick();
        @(negedge clk);
        #1;
    endtask

    task automatic load(input int v);
        cfg_load_en = 1'b1; cfg_offset = ADDR_W'(v);
        tick();
        cfg_load_en = 1'b0;
    endtask

    initial begin
        s_dly = '{0, 0};
        drive();
        cur_req = "R1";
        repeat (4) begin tick(); chk(above_x, 1'b0, "R1 in reset"); end
        rst_n = 1'b1;
        tick(); chk(above_x, 1'b0, "R1 after reset");

        // R5: write up to X+1 = 9 words.
        cur_req = "R5";
        repeat (8) begin wr_cnt++; drive(); tick(); end
        repeat (2) tick();
        chk(above_x, 1'b0, "R2 level=X");
        wr_cnt++; drive(); tick();
        chk(above_x, 1'b0, "R5 first edge");
        tick();
        chk(above_x, 1'b1, "R5 second edge");

        // R4: fetching into the output register drops the level to 8.
        cur_req = "R4";
        occ_i = 1; drive(); tick();
        chk(above_x, 1'b0, "R4 occupied word not counted");
        rd_cnt++; occ_i = 0; drive(); tick();
        chk(above_x, 1'b0, "R4 consume keeps level");

        // R6: reach level 9, then a read lowers it at once.
        cur_req = "R6";
        wr_cnt++; drive(); repeat (2) tick();
        chk(above_x, 1'b1, "R6 level 9");
        occ_i = 1; drive(); tick();
        chk(above_x, 1'b0, "R6 immediate fall");

        // R3: load a lower X, then offer a value without the enable.
        cur_req = "R3";
        load(3);
        chk(above_x, 1'b1, "R3 load X=3");
        load(8);
        chk(above_x, 1'b0, "R3 load X=8");
        cfg_offset = 6'd0; tick(); tick();
        chk(above_x, 1'b0, "R3 ignored without enable");

        // R8: fill memory completely with X = DEPTH-1.
        cur_req = "R8";
        load(DEPTH - 1);
        while (wr_cnt - rd_cnt - occ_i < DEPTH) begin wr_cnt++; drive(); tick(); end
        chk(above_x, 1'b0, "R8 before sync");
        tick(); tick();
        chk(above_x, 1'b1, "R8 full counts as full");
        occ_i = 0; rd_cnt++; occ_i = 1; drive(); tick();
        chk(above_x, 1'b0, "R8 one below full");

        // R7: random traffic across many pointer wraps.
        cur_req = "R7";
        for (int n = 0; n < 4000; n++) begin
            int vis;
            vis = s_dly[1] - rd_cnt - occ_i;
            if (wr_cnt - rd_cnt - occ_i < DEPTH && $urandom_range(0, 2) != 0) wr_cnt++;
            if (occ_i == 0) begin
                if (vis >= 1 && $urandom_range(0, 1) == 1) occ_i = 1;
            end else if ($urandom_range(0, 2) != 0) begin
                rd_cnt++;
                occ_i = (vis >= 1 && $urandom_range(0, 1) == 1) ? 1 : 0;
            end
            if ($urandom_range(0, 40) == 0) begin
                cfg_load_en = 1'b1;
                cfg_offset = ADDR_W'($urandom_range(0, DEPTH - 1));
            end else begin
                cfg_load_en = 1'b0;
                cfg_offset = ADDR_W'($urandom_range(0, DEPTH - 1));
            end
            drive();
            tick();
        end
        cfg_load_en = 1'b0;
        tick();
        chk(wr_cnt > MOD, 1'b1, "R7 pointers wrapped");

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        #(20 * 200000);
        if (!done) begin
            done = 1;
            vectors++;
            miscompares++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end

endmodule